// File: doc/BRIEF.md
# E3 Transmit Overhead Inserter with Error Injection

This block builds the serial bit stream of an E3 transmit frame. A free-running position counter walks through a frame of `FRAME_LEN` bit slots. The block fills the first twelve slots with overhead: a 10-bit alignment word, then an alarm bit, then a national bit. It can also place a 4-bit bit-interleaved parity field in the last four slots. Every other slot carries a payload bit, which the block asks for from its client with a request strobe one cycle ahead of use.

For equipment testing, the block can corrupt its overhead on purpose. Two 5-bit masks are XORed onto the two halves of the alignment word. A 4-bit mask is XORed onto the parity field. The alarm and national bits come from a service register only when their source fields select it; any other source value drives the bit low. All masks, service bits and configuration pass through a small 8-bit register port with registered readback. The block captures them once per frame, so no frame is ever partially modified.

Top module: `e3ovh_inserter`

## Requirements
- R1: After reset, all registers read back as 0, `line_bit_o`, `frame_start_o` and `pay_req_o` are low, and the first frame carries no injected errors.
- R2: `frame_start_o` is high in exactly the cycle that carries slot 0 of each frame, once every `FRAME_LEN` cycles.
- R3: Slots 0..9 carry the word 1111010000, leftmost bit first. Bits 4..0 of the register at 0x48 are XORed onto slots 0..4, with bit 4 applied to slot 0.
- R4: Bits 4..0 of the register at 0x49 are XORed onto slots 5..9, with bit 4 applied to slot 5.
- R5: Slot 10 carries bit 1 of the service register (0x31) when configuration bits [1:0] (0x30) are 00. Otherwise slot 10 is 0.
- R6: Slot 11 carries bit 0 of the service register when configuration bits [3:2] are 00. Otherwise slot 11 is 0.
- R7: With configuration bit 4 set, slots `FRAME_LEN-4+k` (k=0..3) carry the even parity of lane k of the previous frame, XORed with bit 3-k of the register at 0x4A. Lane k holds all transmitted slots whose index mod 4 equals k. Before any full frame has been sent, the parity is 0.
- R8: With configuration bit 4 clear, the last four slots carry payload.
- R9: `pay_req_o` is high only in cycles whose `pay_bit_i` is taken, and that bit appears on `line_bit_o` in the next cycle. `pay_req_o` is low for every overhead slot.
- R10: The block samples masks, service bits and configuration on the clock edge that launches slot 0. A write at any other time changes nothing until the next frame.
- R11: `reg_rdata_o` shows the register addressed in the previous cycle. Bits 7..5 of the mask registers at 0x48 and 0x49, bits 7..4 at 0x4A and bits 7..2 of the service register read as 0. The configuration register reads back all 8 bits. Unmapped addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line bit clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Registered read data for the previous cycle's address |
| pay_bit_i | input | 1 | Payload bit, taken when `pay_req_o` is high |
| pay_req_o | output | 1 | Payload request for the current cycle |
| line_bit_o | output | 1 | Serial transmit line bit |
| frame_start_o | output | 1 | High with slot 0 of each frame |

## Verification
The bench writes registers in the middle of a frame and checks that the current frame keeps the old values. A design that applied writes at once would put a half-masked alignment word on the line. It checks that parity is computed over the bits actually sent, including masked overhead and the previous parity field. A design that summed only payload, or summed bits before the mask, would give wrong parity in the frame that follows any masked frame. It also covers enabling and disabling parity, where a wrong payload request would slip the payload stream by four bits. Finally, it checks readback of bits that cannot be written, and the non-register source values that must force the alarm and national bits low.

// File: rtl/e3ovh_pkg.sv
package e3ovh_pkg;
  localparam logic [7:0] ADDR_CFG  = 8'h30;
  localparam logic [7:0] ADDR_SVC  = 8'h31;
  localparam logic [7:0] ADDR_FHI  = 8'h48;
  localparam logic [7:0] ADDR_FLO  = 8'h49;
  localparam logic [7:0] ADDR_BIPM = 8'h4A;

  localparam int FAW_W   = 10;
  localparam int HALF_W  = 5;
  localparam int PAR_W   = 4;
  localparam int OVH_LEN = FAW_W + 2;
  localparam logic [FAW_W-1:0] FAW_WORD = 10'b1111010000;

  typedef struct packed {
    logic [2:0]        cfg_rsvd;
    logic              par_en;
    logic [1:0]        n_src;
    logic [1:0]        a_src;
    logic              a_val;
    logic              n_val;
    logic [HALF_W-1:0] fas_hi;
    logic [HALF_W-1:0] fas_lo;
    logic [PAR_W-1:0]  par_mask;
  } ovh_set_t;
endpackage

// File: rtl/e3ovh_regs.sv
module e3ovh_regs
  import e3ovh_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       we_i,
  input  logic [7:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output ovh_set_t   live_o
);
  logic [7:0]        cfg_q;
  logic [1:0]        svc_q;
  logic [HALF_W-1:0] fhi_q;
  logic [HALF_W-1:0] flo_q;
  logic [PAR_W-1:0]  pm_q;
  logic [7:0]        rdata_q;
  logic [7:0]        rd_mux;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
      svc_q <= '0;
      fhi_q <= '0;
      flo_q <= '0;
      pm_q  <= '0;
    end else if (we_i) begin
      case (addr_i)
        ADDR_CFG:  cfg_q <= wdata_i;
        ADDR_SVC:  svc_q <= wdata_i[1:0];
        ADDR_FHI:  fhi_q <= wdata_i[HALF_W-1:0];
        ADDR_FLO:  flo_q <= wdata_i[HALF_W-1:0];
        ADDR_BIPM: pm_q  <= wdata_i[PAR_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr_i)
      ADDR_CFG:  rd_mux = cfg_q;
      ADDR_SVC:  rd_mux = {6'b0, svc_q};
      ADDR_FHI:  rd_mux = {{(8-HALF_W){1'b0}}, fhi_q};
      ADDR_FLO:  rd_mux = {{(8-HALF_W){1'b0}}, flo_q};
      ADDR_BIPM: rd_mux = {{(8-PAR_W){1'b0}}, pm_q};
      default:   rd_mux = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_mux;
  end

  assign rdata_o = rdata_q;

  always_comb begin
    live_o.cfg_rsvd = cfg_q[7:5];
    live_o.par_en   = cfg_q[4];
    live_o.n_src    = cfg_q[3:2];
    live_o.a_src    = cfg_q[1:0];
    live_o.a_val    = svc_q[1];
    live_o.n_val    = svc_q[0];
    live_o.fas_hi   = fhi_q;
    live_o.fas_lo   = flo_q;
    live_o.par_mask = pm_q;
  end

  // R1: reset clears every register
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (fhi_q == '0 && flo_q == '0 && pm_q == '0 && cfg_q == '0 && svc_q == '0));

  // R11: unwritable bits of the upper mask read as zero
  a_r11_pad_zero: assert property (@(posedge clk) disable iff (rst)
    (addr_i == ADDR_FHI) |=> (rdata_o[7:HALF_W] == '0));

  // R11: unmapped addresses read as zero
  a_r11_unmapped: assert property (@(posedge clk) disable iff (rst)
    (addr_i != ADDR_CFG && addr_i != ADDR_SVC && addr_i != ADDR_FHI &&
     addr_i != ADDR_FLO && addr_i != ADDR_BIPM) |=> (rdata_o == 8'h00));
endmodule

// File: rtl/e3ovh_frame_ctr.sv
module e3ovh_frame_ctr
  import e3ovh_pkg::*;
#(
  parameter int FRAME_LEN = 1536,
  localparam int POS_W = $clog2(FRAME_LEN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tail_pay_i,
  output logic [POS_W-1:0] pos_o,
  output logic             last_o,
  output logic             pay_req_o
);
  localparam int TAIL_START = FRAME_LEN - PAR_W;

  logic [POS_W-1:0] pos_q;
  logic [POS_W-1:0] pos_nx;
  logic             req_q;
  logic             nx_pay;

  assign last_o = (pos_q == POS_W'(FRAME_LEN - 1));
  assign pos_nx = last_o ? '0 : pos_q + 1'b1;
  assign nx_pay = (pos_nx >= POS_W'(OVH_LEN)) &&
                  (tail_pay_i || (pos_nx < POS_W'(TAIL_START)));

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q <= '0;
      req_q <= 1'b0;
    end else begin
      pos_q <= pos_nx;
      req_q <= nx_pay;
    end
  end

  assign pos_o     = pos_q;
  assign pay_req_o = req_q;

  // R2: position stays inside the frame
  always_comb begin
    a_r2_in_range: assert (rst || pos_q < POS_W'(FRAME_LEN));
  end

  // R2: last slot is followed by slot 0
  a_r2_wrap: assert property (@(posedge clk) disable iff (rst)
    last_o |=> (pos_q == '0));

  // R9: no request lands on an overhead slot
  a_r9_req_payload_only: assert property (@(posedge clk) disable iff (rst)
    req_q |-> (pos_q >= POS_W'(OVH_LEN)));
endmodule

// File: rtl/e3ovh_parity.sv
module e3ovh_parity
  import e3ovh_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_i,
  input  logic [1:0]       lane_i,
  input  logic             last_i,
  output logic [PAR_W-1:0] prev_o
);
  logic [PAR_W-1:0] acc_q;
  logic [PAR_W-1:0] acc_nx;
  logic [PAR_W-1:0] prev_q;

  always_comb begin
    acc_nx = acc_q;
    acc_nx[2'd3 - lane_i] = acc_q[2'd3 - lane_i] ^ bit_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= '0;
      prev_q <= '0;
    end else if (last_i) begin
      acc_q  <= '0;
      prev_q <= acc_nx;
    end else begin
      acc_q  <= acc_nx;
    end
  end

  assign prev_o = prev_q;

  // R7: stored parity changes only at a frame boundary
  a_r7_prev_hold: assert property (@(posedge clk) disable iff (rst)
    !last_i |=> $stable(prev_q));
endmodule

// File: rtl/e3ovh_inserter.sv
module e3ovh_inserter
  import e3ovh_pkg::*;
#(
  parameter int FRAME_LEN = 1536
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       reg_we_i,
  input  logic [7:0] reg_addr_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o,
  input  logic       pay_bit_i,
  output logic       pay_req_o,
  output logic       line_bit_o,
  output logic       frame_start_o
);
  localparam int POS_W      = $clog2(FRAME_LEN);
  localparam int TAIL_START = FRAME_LEN - PAR_W;

  ovh_set_t         live;
  ovh_set_t         snap_q;
  ovh_set_t         eff;
  logic [POS_W-1:0] pos;
  logic             last;
  logic [PAR_W-1:0] prev_par;
  logic             bit_nx;
  logic             line_q;
  logic             fs_q;
  logic             at_head;
  logic [3:0]       faw_idx;
  logic [FAW_W-1:0] faw_tx;
  logic [1:0]       lane;

  e3ovh_regs u_regs (
    .clk     (clk),
    .rst     (rst),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .live_o  (live)
  );

  e3ovh_frame_ctr #(.FRAME_LEN(FRAME_LEN)) u_ctr (
    .clk        (clk),
    .rst        (rst),
    .tail_pay_i (!eff.par_en),
    .pos_o      (pos),
    .last_o     (last),
    .pay_req_o  (pay_req_o)
  );

  assign at_head = (pos == '0);
  assign eff     = at_head ? live : snap_q;

  always_ff @(posedge clk) begin
    if (rst)          snap_q <= '0;
    else if (at_head) snap_q <= live;
  end

  assign faw_tx  = FAW_WORD ^ {eff.fas_hi, eff.fas_lo};
  assign faw_idx = 4'd9 - pos[3:0];
  assign lane    = pos[1:0];

  always_comb begin
    if (pos < POS_W'(FAW_W))
      bit_nx = faw_tx[faw_idx];
    else if (pos == POS_W'(FAW_W))
      bit_nx = (eff.a_src == 2'b00) ? eff.a_val : 1'b0;
    else if (pos == POS_W'(FAW_W + 1))
      bit_nx = (eff.n_src == 2'b00) ? eff.n_val : 1'b0;
    else if (eff.par_en && pos >= POS_W'(TAIL_START))
      bit_nx = prev_par[2'd3 - lane] ^ eff.par_mask[2'd3 - lane];
    else
      bit_nx = pay_bit_i;
  end

  e3ovh_parity u_par (
    .clk    (clk),
    .rst    (rst),
    .bit_i  (bit_nx),
    .lane_i (lane),
    .last_i (last),
    .prev_o (prev_par)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q <= 1'b0;
      fs_q   <= 1'b0;
    end else begin
      line_q <= bit_nx;
      fs_q   <= at_head;
    end
  end

  assign line_bit_o    = line_q;
  assign frame_start_o = fs_q;

  // R9: a requested payload bit reaches the line one cycle later
  a_r9_passthru: assert property (@(posedge clk) disable iff (rst)
    pay_req_o |=> (line_bit_o == $past(pay_bit_i)));

  // R9: the frame marker never coincides with a request
  a_r9_no_req_at_start: assert property (@(posedge clk) disable iff (rst)
    frame_start_o |-> !pay_req_o);

  // R10: captured settings hold for the whole frame
  a_r10_snap_stable: assert property (@(posedge clk) disable iff (rst)
    !at_head |=> $stable(snap_q));

  // R2: marker is a single-cycle pulse
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
    frame_start_o |=> !frame_start_o);
endmodule

// File: tb/e3ovh_inserter_bench.sv
module e3ovh_inserter_bench;
  localparam int L = 1536;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_we = 1'b0;
  logic [7:0] reg_addr = 8'h00;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       pay_bit = 1'b0;
  logic       pay_req, line_bit, frame_start;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  e3ovh_inserter #(.FRAME_LEN(L)) u_e3ovh_inserter (
    .clk(clk), .rst(rst), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .pay_bit_i(pay_bit),
    .pay_req_o(pay_req), .line_bit_o(line_bit), .frame_start_o(frame_start)
  );

  // behavioural reference model
  int       m_pos;
  bit [7:0] m_cfg, s_cfg;
  bit [1:0] m_svc, s_svc;
  bit [4:0] m_fhi, m_flo, s_fhi, s_flo;
  bit [3:0] m_pm, s_pm;
  bit [3:0] m_acc, m_prev;
  bit       e_line, e_fs, e_req;
  bit [7:0] e_rdata;
  string    e_tag;

  function automatic bit [7:0] m_read(input bit [7:0] a);
    case (a)
      8'h30: return m_cfg;
      8'h31: return {6'b0, m_svc};
      8'h48: return {3'b0, m_fhi};
      8'h49: return {3'b0, m_flo};
      8'h4A: return {4'b0, m_pm};
      default: return 8'h00;
    endcase
  endfunction

  function automatic bit m_is_pay(input int p, input bit par_on);
    return (p >= 12) && (!par_on || p < L - 4);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_pos = 0; m_cfg = 0; m_svc = 0; m_fhi = 0; m_flo = 0; m_pm = 0;
      s_cfg = 0; s_svc = 0; s_fhi = 0; s_flo = 0; s_pm = 0;
      m_acc = 0; m_prev = 0; e_line = 0; e_fs = 0; e_req = 0; e_rdata = 0;
      e_tag = "R1";
    end else begin
      bit [9:0] faw;
      bit       b;
      int       ln;
      if (m_pos == 0) begin
        s_cfg = m_cfg; s_svc = m_svc; s_fhi = m_fhi; s_flo = m_flo; s_pm = m_pm;
      end
      faw = 10'b1111010000 ^ {s_fhi, s_flo};
      ln  = m_pos % 4;
      if (m_pos < 10) begin
        b = faw[9 - m_pos];
        e_tag = (m_pos < 5) ? "R3 R10" : "R4 R10";
      end else if (m_pos == 10) begin
        b = (s_cfg[1:0] == 2'b00) ? s_svc[1] : 1'b0;
        e_tag = "R5";
      end else if (m_pos == 11) begin
        b = (s_cfg[3:2] == 2'b00) ? s_svc[0] : 1'b0;
        e_tag = "R6";
      end else if (s_cfg[4] && m_pos >= L - 4) begin
        b = m_prev[3 - ln] ^ s_pm[3 - ln];
        e_tag = "R7";
      end else begin
        b = pay_bit;
        e_tag = (m_pos >= L - 4) ? "R8" : "R9";
      end
      e_line = b;
      e_fs   = (m_pos == 0);
      m_acc[3 - ln] = m_acc[3 - ln] ^ b;
      if (m_pos == L - 1) begin
        m_prev = m_acc;
        m_acc  = 0;
      end
      e_rdata = m_read(reg_addr);
      if (reg_we) begin
        case (reg_addr)
          8'h30: m_cfg = reg_wdata;
          8'h31: m_svc = reg_wdata[1:0];
          8'h48: m_fhi = reg_wdata[4:0];
          8'h49: m_flo = reg_wdata[4:0];
          8'h4A: m_pm  = reg_wdata[3:0];
          default: ;
        endcase
      end
      m_pos = (m_pos + 1) % L;
      e_req = m_is_pay(m_pos, s_cfg[4]);
    end
  end

  // compare on every cycle, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      n_checks++;
      if (line_bit !== e_line) begin
        n_errors++;
        $display("FAIL %s line_bit got %0b expected %0b", e_tag, line_bit, e_line);
      end
      n_checks++;
      if (frame_start !== e_fs) begin
        n_errors++;
        $display("FAIL R2 frame_start got %0b expected %0b", frame_start, e_fs);
      end
      n_checks++;
      if (pay_req !== e_req) begin
        n_errors++;
        $display("FAIL R9 pay_req got %0b expected %0b", pay_req, e_req);
      end
      n_checks++;
      if (reg_rdata !== e_rdata) begin
        n_errors++;
        $display("FAIL R11 reg_rdata got %02h expected %02h", reg_rdata, e_rdata);
      end
    end
  end

  task automatic wr(input bit [7:0] a, input bit [7:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_check(input bit [7:0] a, input bit [7:0] exp, input string tag);
    reg_addr = a;
    @(negedge clk);
    n_checks++;
    if (reg_rdata !== exp) begin
      n_errors++;
      $display("FAIL %s read %02h got %02h expected %02h", tag, a, reg_rdata, exp);
    end
  endtask

  task automatic to_frame(input int off);
    do @(negedge clk); while (!frame_start);
    repeat (off) @(negedge clk);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      pay_bit = 1'($urandom);
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset values
    n_checks++;
    if (line_bit !== 1'b0 || frame_start !== 1'b0 || pay_req !== 1'b0) begin
      n_errors++;
      $display("FAIL R1 outputs got %0b%0b%0b expected 000", line_bit, frame_start, pay_req);
    end
    rd_check(8'h48, 8'h00, "R1");
    rd_check(8'h49, 8'h00, "R1");
    rd_check(8'h4A, 8'h00, "R1");
    rd_check(8'h30, 8'h00, "R1");
    rd_check(8'h31, 8'h00, "R1");
    // mid-frame writes: R10 defers them, R3/R4/R7 use them next frame
    to_frame(300);
    wr(8'h48, 8'hFF);
    wr(8'h49, 8'hE5);
    wr(8'h4A, 8'hF9);
    wr(8'h30, 8'hF0);
    wr(8'h31, 8'hFE);
    rd_check(8'h48, 8'h1F, "R11");
    rd_check(8'h49, 8'h05, "R11");
    rd_check(8'h4A, 8'h09, "R11");
    rd_check(8'h30, 8'hF0, "R11");
    rd_check(8'h31, 8'h02, "R11");
    rd_check(8'h77, 8'h00, "R11");
    // R5: non-register alarm source forces 0
    to_frame(700);
    wr(8'h30, 8'h11);
    wr(8'h31, 8'h03);
    wr(8'h48, 8'h0A);
    // R6 and R8: national source off register, parity disabled
    to_frame(50);
    wr(8'h30, 8'h04);
    wr(8'h49, 8'h00);
    // R7: parity on again, write just before the boundary
    to_frame(L - 4);
    wr(8'h30, 8'h10);
    wr(8'h4A, 8'h06);
    to_frame(20);
    wr(8'h48, 8'h00);
    to_frame(0);
    to_frame(0);
    repeat (20) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    done = 1'b1;
    n_checks++;
    n_errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule